// File: doc/BRIEF.md
# Microcoded ALU with Shifter

This block is the arithmetic stage of a microprogrammed data path. Two operands arrive on the A and B inputs. Each operand has its own enable line, and a deasserted enable forces that operand to zero. The A operand can be complemented after gating. A two-bit function code selects AND, OR, complement-of-B, or a sum that takes a carry-in. Because gating, inversion and carry are separate lines, a small function code can still produce increments, negation, the constants 0, 1 and -1, and plain pass-through of either operand.

The function output then feeds a shifter. The shifter either passes the value through, shifts it left by one byte with zero fill, or shifts it right by one bit while keeping the sign bit, which halves a two's complement value. Asserting both shift lines at once is not a legal control word. In that case the value passes through unshifted and an indication is raised. Negative and zero status are taken from the function output before the shifter and are captured into flag flops on each rising clock edge.

Top module: `mc_alu_shift`

## Requirements
- R1: When `ena_a_i` is low the A operand is treated as zero, and when `ena_b_i` is low the B operand is treated as zero, for every function.
- R2: When `inv_a_i` is high the gated A operand is bitwise complemented before the function is applied. With `ena_a_i` low this gives an all-ones operand.
- R3: Function code 2'b00 yields the bitwise AND of the two prepared operands.
- R4: Function code 2'b01 yields the bitwise OR of the two prepared operands.
- R5: Function code 2'b10 yields the bitwise complement of the gated B operand.
- R6: Function code 2'b11 yields A + B + `cin_i` modulo 2^32. `cin_i` has no effect under any other function code.
- R7: With `shl_byte_i` high and `sar_one_i` low, `result_o` is the function output shifted left by 8 bits, and bits 7:0 are zero.
- R8: With `sar_one_i` high and `shl_byte_i` low, `result_o` is the function output shifted right by 1 bit, and bit 31 is copied from the function output's bit 31.
- R9: With both shift lines low, `result_o` equals the function output unchanged and `illegal_o` is low.
- R10: With both shift lines high, `result_o` equals the unshifted function output and `illegal_o` is high. `illegal_o` is low whenever at most one shift line is high.
- R11: On each rising clock edge out of reset, `neg_o` takes bit 31 of the pre-shift function output and `zero_o` takes whether all 32 pre-shift bits are zero. Neither flag depends on the shift lines.
- R12: While `rst_n` is low, both `neg_o` and `zero_o` are held at 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset for the flags |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| fn_i | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 SUM |
| ena_a_i | input | 1 | Gate operand A into the ALU |
| ena_b_i | input | 1 | Gate operand B into the ALU |
| inv_a_i | input | 1 | Complement the gated A operand |
| cin_i | input | 1 | Carry into the least significant bit of the sum |
| shl_byte_i | input | 1 | Shift left by 8 with zero fill |
| sar_one_i | input | 1 | Arithmetic shift right by 1 |
| result_o | output | 32 | Shifted result (combinational) |
| neg_o | output | 1 | Registered negative flag |
| zero_o | output | 1 | Registered zero flag |
| illegal_o | output | 1 | Both shift lines asserted (combinational) |

## Verification
The checker watches, on every cycle, the relationship between the pre-shift function output and the shifter output. It covers pass-through, the zero-filled low byte after a left shift, sign retention after a right shift, and the illegal-shift indication. It also checks that both flags reflect the previous cycle's pre-shift value, and that a gated-off B under the complement function yields all ones. The exact values of each function, the gating and inversion constants, carry wrap-around, and flags that disagree with the shifted result are shown only by the bench's directed and pseudo-random scenarios. Those scenarios are compared against an independent reference model.

// File: rtl/mc_alu_pkg.sv
`timescale 1ns/1ps
package mc_alu_pkg;
   typedef enum logic [1:0] {
      FN_AND  = 2'b00,
      FN_OR   = 2'b01,
      FN_NOTB = 2'b10,
      FN_SUM  = 2'b11
   } alu_fn_e;
endpackage

// File: rtl/alu_operand_gate.sv
`timescale 1ns/1ps
module alu_operand_gate #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_raw,
   input  logic [WIDTH-1:0] b_raw,
   input  logic             ena_a,
   input  logic             ena_b,
   input  logic             inv_a,
   output logic [WIDTH-1:0] opa,
   output logic [WIDTH-1:0] opb
);
   logic [WIDTH-1:0] a_gated;

   // gating happens before inversion, so a disabled A that is inverted becomes all ones
   assign a_gated = ena_a ? a_raw : '0;
   assign opa     = inv_a ? ~a_gated : a_gated;
   assign opb     = ena_b ? b_raw : '0;
endmodule

// File: rtl/alu_func_core.sv
`timescale 1ns/1ps
module alu_func_core
   import mc_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  alu_fn_e          fn,
   input  logic             cin,
   output logic [WIDTH-1:0] y
);
   localparam int unsigned PADW = WIDTH - 1;

   logic [WIDTH-1:0] sum;
   assign sum = opa + opb + {{PADW{1'b0}}, cin};

   always_comb begin
      unique case (fn)
         FN_AND:  y = opa & opb;
         FN_OR:   y = opa | opb;
         FN_NOTB: y = ~opb;
         FN_SUM:  y = sum;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/alu_result_shifter.sv
`timescale 1ns/1ps
module alu_result_shifter #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned SHL_AMT = 8
) (
   input  logic [WIDTH-1:0] y,
   input  logic             shl,
   input  logic             sar,
   output logic [WIDTH-1:0] res,
   output logic             illegal
);
   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] y_shl;
   logic [WIDTH-1:0] y_sar;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SHL_AMT) begin : g_shl_src
         assign y_shl[i] = y[i-SHL_AMT];
      end else begin : g_shl_fill
         assign y_shl[i] = 1'b0;
      end
      if (i == MSB) begin : g_sar_sign
         assign y_sar[i] = y[MSB];
      end else begin : g_sar_src
         assign y_sar[i] = y[i+1];
      end
   end

   always_comb begin
      illegal = shl & sar;
      unique case ({shl, sar})
         2'b10:   res = y_shl;
         2'b01:   res = y_sar;
         default: res = y;
      endcase
   end
endmodule

// File: rtl/mc_alu_shift.sv
`timescale 1ns/1ps
module mc_alu_shift
   import mc_alu_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned SHL_AMT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       fn_i,
   input  logic             ena_a_i,
   input  logic             ena_b_i,
   input  logic             inv_a_i,
   input  logic             cin_i,
   input  logic             shl_byte_i,
   input  logic             sar_one_i,
   output logic [WIDTH-1:0] result_o,
   output logic             neg_o,
   output logic             zero_o,
   output logic             illegal_o
);
   localparam int unsigned MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("mc_alu_shift: WIDTH must be at least 2");
   end
   if (SHL_AMT == 0 || SHL_AMT >= WIDTH) begin : g_chk_shl
      $error("mc_alu_shift: SHL_AMT must lie in 1..WIDTH-1");
   end

   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] opb;
   logic [WIDTH-1:0] alu_y;
   alu_fn_e          fn_sel;

   assign fn_sel = alu_fn_e'(fn_i);

   alu_operand_gate #(.WIDTH(WIDTH)) u_gate (
      .a_raw (a_i),
      .b_raw (b_i),
      .ena_a (ena_a_i),
      .ena_b (ena_b_i),
      .inv_a (inv_a_i),
      .opa   (opa),
      .opb   (opb)
   );

   alu_func_core #(.WIDTH(WIDTH)) u_core (
      .opa (opa),
      .opb (opb),
      .fn  (fn_sel),
      .cin (cin_i),
      .y   (alu_y)
   );

   alu_result_shifter #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_shift (
      .y       (alu_y),
      .shl     (shl_byte_i),
      .sar     (sar_one_i),
      .res     (result_o),
      .illegal (illegal_o)
   );

   // status is taken ahead of the shifter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_o  <= 1'b0;
         zero_o <= 1'b0;
      end else begin
         neg_o  <= alu_y[MSB];
         zero_o <= (alu_y == '0);
      end
   end
endmodule

// File: rtl/alu_shift_chk.sv
`timescale 1ns/1ps
module alu_shift_chk #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned SHL_AMT = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       fn_i,
   input logic             ena_b_i,
   input logic             shl_byte_i,
   input logic             sar_one_i,
   input logic [WIDTH-1:0] alu_y,
   input logic [WIDTH-1:0] result_o,
   input logic             illegal_o,
   input logic             neg_o,
   input logic             zero_o
);
   localparam int unsigned MSB = WIDTH - 1;

   // R9
   p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!shl_byte_i && !sar_one_i) |-> (result_o == alu_y && !illegal_o));

   // R7
   p_shl_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (shl_byte_i && !sar_one_i) |-> (result_o[SHL_AMT-1:0] == '0 && !illegal_o));

   // R8
   p_sar_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sar_one_i && !shl_byte_i) |-> (result_o[MSB] == alu_y[MSB] && !illegal_o));

   // R10
   p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (shl_byte_i && sar_one_i) |-> (illegal_o && result_o == alu_y));

   // R11
   p_neg_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (neg_o == $past(alu_y[MSB])));

   p_zero_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (zero_o == ($past(alu_y) == '0)));

   // R5 with R1: complement of a gated-off B is all ones
   p_notb_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fn_i == 2'b10 && !ena_b_i) |-> (alu_y == '1));
endmodule

bind mc_alu_shift alu_shift_chk #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fn_i       (fn_i),
   .ena_b_i    (ena_b_i),
   .shl_byte_i (shl_byte_i),
   .sar_one_i  (sar_one_i),
   .alu_y      (alu_y),
   .result_o   (result_o),
   .illegal_o  (illegal_o),
   .neg_o      (neg_o),
   .zero_o     (zero_o)
);

// File: tb/tb_mc_alu_shift.sv
`timescale 1ns/1ps
module tb_mc_alu_shift;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a_i = '0, b_i = '0;
   logic [1:0]  fn_i = '0;
   logic        ena_a_i = 1'b0, ena_b_i = 1'b0, inv_a_i = 1'b0, cin_i = 1'b0;
   logic        shl_byte_i = 1'b0, sar_one_i = 1'b0;
   logic [31:0] result_o;
   logic        neg_o, zero_o, illegal_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mc_alu_shift dut (
      .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .fn_i(fn_i),
      .ena_a_i(ena_a_i), .ena_b_i(ena_b_i), .inv_a_i(inv_a_i), .cin_i(cin_i),
      .shl_byte_i(shl_byte_i), .sar_one_i(sar_one_i),
      .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o), .illegal_o(illegal_o)
   );

   function automatic void check(input string tag, input string what,
                                 input longint got, input longint exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
      end
   endfunction

   // reference: behavioural arithmetic on integers
   function automatic longint unsigned ref_fn(input logic [31:0] a, input logic [31:0] b,
         input logic [1:0] fn, input bit ea, input bit eb, input bit ia, input bit ci);
      longint unsigned x, z, m;
      m = 64'hFFFF_FFFF;
      x = ea ? a : 0;
      if (ia) x = m - x;
      z = eb ? b : 0;
      case (fn)
         2'd0: return x & z;
         2'd1: return x | z;
         2'd2: return m - z;
         default: return (x + z + ci) % 64'h1_0000_0000;
      endcase
   endfunction

   task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] b,
         input logic [1:0] fn, input bit ea, input bit eb, input bit ia, input bit ci,
         input bit sl, input bit sr);
      longint unsigned y, r;
      @(negedge clk);
      a_i = a; b_i = b; fn_i = fn; ena_a_i = ea; ena_b_i = eb; inv_a_i = ia;
      cin_i = ci; shl_byte_i = sl; sar_one_i = sr;
      y = ref_fn(a, b, fn, ea, eb, ia, ci);
      if (sl && !sr)      r = (y * 256) % 64'h1_0000_0000;
      else if (sr && !sl) r = (y / 2) + ((y >= 64'h8000_0000) ? 64'h8000_0000 : 0);
      else                r = y;
      #5;
      check(tag, "result", result_o, r);
      check(sl && sr ? "R10" : tag, "illegal", illegal_o, (sl && sr) ? 1 : 0);
      @(posedge clk); #5;
      check("R11", "neg", neg_o, (y >= 64'h8000_0000) ? 1 : 0);
      check("R11", "zero", zero_o, (y == 0) ? 1 : 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] s;
      // R12: flags held clear in reset even with a negative ALU output
      a_i = 32'h8000_0000; ena_a_i = 1'b1; fn_i = 2'b01;
      repeat (3) @(posedge clk);
      #5;
      check("R12", "neg in reset", neg_o, 0);
      check("R12", "zero in reset", zero_o, 0);
      @(negedge clk); rst_n = 1'b1;

      apply("R1", 32'hFFFF_0000, 32'h0000_1234, 2'b01, 0, 1, 0, 0, 0, 0);
      apply("R1", 32'h0000_0005, 32'h0000_0009, 2'b11, 1, 0, 0, 0, 0, 0);
      apply("R2", 32'h0000_0003, 32'h0000_000A, 2'b11, 1, 1, 1, 1, 0, 0);
      apply("R2", 32'h1234_5678, 32'hCAFE_F00D, 2'b00, 0, 1, 1, 0, 0, 0);
      apply("R3", 32'hF0F0_F0F0, 32'hFF00_FF00, 2'b00, 1, 1, 0, 0, 0, 0);
      apply("R4", 32'hF0F0_0000, 32'h0000_0F0F, 2'b01, 1, 1, 0, 0, 0, 0);
      apply("R5", 32'h0000_0000, 32'h0000_FFFF, 2'b10, 1, 1, 0, 0, 0, 0);
      apply("R5", 32'h0000_0000, 32'h1234_5678, 2'b10, 0, 0, 0, 0, 0, 0);
      apply("R6", 32'h0000_0000, 32'h0000_0029, 2'b11, 0, 1, 0, 1, 0, 0);
      apply("R6", 32'hFFFF_FFFF, 32'h0000_0000, 2'b11, 1, 1, 0, 1, 0, 0);
      apply("R6", 32'h0000_00F0, 32'h0000_000F, 2'b00, 1, 1, 0, 1, 0, 0);
      apply("R7", 32'h1234_5678, 32'h0, 2'b01, 1, 0, 0, 0, 1, 0);
      apply("R8", 32'hFFFF_FFF2, 32'h0, 2'b01, 1, 0, 0, 0, 0, 1);
      apply("R8", 32'h0000_0070, 32'h0, 2'b01, 1, 0, 0, 0, 0, 1);
      apply("R9", 32'h89AB_CDEF, 32'h0, 2'b01, 1, 0, 0, 0, 0, 0);
      apply("R10", 32'h8765_4321, 32'h0, 2'b01, 1, 0, 0, 0, 1, 1);
      apply("R11", 32'h8000_0001, 32'h0, 2'b01, 1, 0, 0, 0, 1, 0);
      apply("R11", 32'h0100_0000, 32'h0, 2'b01, 1, 0, 0, 0, 1, 0);

      s = 32'h1357_9BDF;
      for (int i = 0; i < 80; i++) begin
         logic [31:0] ra, rb;
         string t;
         s = s * 32'd1664525 + 32'd1013904223; ra = s;
         s = s * 32'd1664525 + 32'd1013904223; rb = s;
         case (s[9:8])
            2'd0: t = "R3";
            2'd1: t = "R4";
            2'd2: t = "R5";
            default: t = "R6";
         endcase
         apply(t, ra, rb, s[9:8], s[2], s[3], s[4], s[5], s[6], s[7] & ~s[6]);
      end
      finish_run();
   end
endmodule